// File: doc/BRIEF.md
# Multi-receiver IQ frame packer

The packer assembles fixed-size frames for a byte-wide host link. Several digital receivers each deliver 24-bit I/Q sample pairs, and one transmit-audio source delivers 16-bit samples. Every frame begins with a short header: three sync bytes, then five control bytes. These come from a 40-bit register input, and the packer samples that register once per frame. The rest of the frame is made of sample groups. One group carries the I and Q words of every receiver and then the audio word. Any bytes that remain after the last whole group are filled with zeros.

A group is captured from all sources in the same cycle, and only when every source presents a valid sample, so the receiver streams stay aligned with each other. If a complete new set of samples arrives while the previous group is still being sent, it is refused and a one-cycle overflow pulse is raised. The output is a byte stream with valid/ready flow control. While the sink is stalled, every piece of internal state is held.

Top module: `iq_frame_packer`

## Requirements
- R1: A frame is FRAME_BYTES (default 512) accepted bytes long, and byte 0 of the next frame follows the last byte of the previous one directly.
- R2: Frame bytes 0, 1 and 2 are each 0x7F and are presented with out_valid high.
- R3: Frame bytes 3 to 7 are C1 to C5, where C1 is ctrl_bytes[39:32], C2 is [31:24], C3 is [23:16], C4 is [15:8] and C5 is [7:0]. They are presented with out_valid high.
- R4: ctrl_bytes is sampled in the cycle when frame byte 0 is accepted, and a change to ctrl_bytes after that cycle has no effect on the current frame's header.
- R5: The bytes of a group are sent in this order: receiver 0 I, receiver 0 Q, receiver 1 I, receiver 1 Q, and so on, then audio. Each 24-bit word is sent as three bytes, most significant first, and the audio word as two bytes, high byte first. Receiver r occupies bits [24r+23:24r] of rx_i and rx_q.
- R6: A group is captured only in a cycle when every rx_valid bit and aud_valid are high and no earlier group is still pending (or its last byte is accepted in that same cycle). Inside the group area, out_valid is low while no group is held.
- R7: While out_valid is high and out_ready is low, out_valid and out_data stay unchanged in the next cycle.
- R8: When the payload area (FRAME_BYTES - 8) is not a multiple of the group size (6*NUM_RX + 2 bytes), the bytes after the last whole group are 0x00, presented with out_valid high.
- R9: overflow is high for exactly the cycle after a cycle in which all sources were valid but the new samples could not be captured.
- R10: After reset, out_valid is high, out_data is 0x7F and overflow is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 24*NUM_RX | I samples, receiver r in bits [24r+23:24r] |
| rx_q | input | 24*NUM_RX | Q samples, same layout as rx_i |
| rx_valid | input | NUM_RX | Per-receiver sample valid |
| aud_sample | input | 16 | Transmit-audio sample |
| aud_valid | input | 1 | Audio sample valid |
| ctrl_bytes | input | 40 | C1 to C5, with C1 in the top byte |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| overflow | output | 1 | Pulse: a full sample set was refused |

## Verification
The assertions rely on three assumptions about the inputs. The sink may lower out_ready at any time. The sources may assert their valid flags in any combination. ctrl_bytes may change in any cycle. None of them assumes the sources slow down when the packer is busy. The stimulus uses each of these freedoms on purpose: phases with every source valid on every cycle force refused sets, random valid patterns leave gaps in the group area, out_ready is dropped at random, and ctrl_bytes is rewritten in the middle of frames. A second instance with three receivers leaves a remainder after the last group, so the zero-fill path is also covered.

// File: rtl/iq_frame_packer.sv
module iq_frame_packer #(
  parameter int NUM_RX      = 2,
  parameter int FRAME_BYTES = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [24*NUM_RX-1:0]   rx_i,
  input  logic [24*NUM_RX-1:0]   rx_q,
  input  logic [NUM_RX-1:0]      rx_valid,
  input  logic [15:0]            aud_sample,
  input  logic                   aud_valid,
  input  logic [39:0]            ctrl_bytes,
  output logic [7:0]             out_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   overflow
);

  localparam int HDR  = 8;
  localparam int GRP  = 6 * NUM_RX + 2;
  localparam int NGRP = (FRAME_BYTES - HDR) / GRP;
  localparam int GEND = HDR + NGRP * GRP;
  localparam int PW   = $clog2(FRAME_BYTES);
  localparam int GW   = $clog2(GRP);
  localparam int SW   = GRP * 8;
  localparam logic [7:0] SYNC = 8'h7F;

  logic [PW-1:0] pos;
  logic [GW-1:0] gidx;
  logic [SW-1:0] shreg, grp_word;
  logic          buf_full;
  logic [39:0]   ctrl_q;
  logic [63:0]   hdr_word;

  wire in_hdr   = {1'b0, pos} < (PW+1)'(HDR);
  wire in_grp   = !in_hdr && ({1'b0, pos} < (PW+1)'(GEND));
  wire fire     = out_valid && out_ready;
  wire grp_done = fire && in_grp && (gidx == GW'(GRP - 1));
  wire all_v    = (&rx_valid) && aud_valid;
  wire load     = all_v && (!buf_full || grp_done);

  genvar r;
  generate
    for (r = 0; r < NUM_RX; r++) begin : g_pack
      assign grp_word[SW-1-48*r -: 48] = {rx_i[24*r +: 24], rx_q[24*r +: 24]};
    end
  endgenerate
  assign grp_word[15:0] = aud_sample;

  assign hdr_word  = {SYNC, SYNC, SYNC, ctrl_q} >> {3'd7 - pos[2:0], 3'b000};
  assign out_data  = in_hdr ? hdr_word[7:0] : in_grp ? shreg[SW-1 -: 8] : 8'h00;
  assign out_valid = !in_grp || buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      gidx     <= '0;
      shreg    <= '0;
      buf_full <= 1'b0;
      ctrl_q   <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= all_v && !load;
      if (fire) begin
        pos <= (pos == PW'(FRAME_BYTES - 1)) ? '0 : pos + 1'b1;
        if (pos == '0) ctrl_q <= ctrl_bytes;
        if (in_grp) begin
          gidx  <= grp_done ? '0 : gidx + 1'b1;
          shreg <= shreg << 8;
        end
      end
      if (load) begin
        shreg    <= grp_word;
        buf_full <= 1'b1;
      end else if (grp_done) begin
        buf_full <= 1'b0;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && pos == PW'(FRAME_BYTES - 1) |=> out_valid && out_data == SYNC); // R1

  AST_FULL_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_full ##1 buf_full |-> $past(all_v)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(buf_full) && $past(all_v)); // R9

endmodule

// File: tb/test_iq_frame_packer.sv
module packer_ref_model #(
  parameter int NRX   = 2,
  parameter int FRAME = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic [24*NRX-1:0] rx_i,
  input logic [24*NRX-1:0] rx_q,
  input logic [NRX-1:0]    rx_valid,
  input logic [15:0]       aud,
  input logic              aud_valid,
  input logic [39:0]       ctrl,
  input logic              ready,
  input logic [7:0]        dut_data,
  input logic              dut_valid,
  input logic              dut_ovf
);
  localparam int G    = 6 * NRX + 2;
  localparam int NG   = (FRAME - 8) / G;
  localparam int GEND = 8 + NG * G;

  int n_chk = 0, n_fail = 0, frames = 0;
  int pos = 0, gidx = 0;
  byte unsigned q[$];
  bit full = 0, ov_exp = 0;
  logic [39:0] ctrl_q = '0;
  bit pv = 0, pr = 1;
  logic [7:0] pd = 0;
  bit was_rst = 1;

  function automatic bit exp_valid();
    return (pos < 8) || (pos >= GEND) || full;
  endfunction

  function automatic byte unsigned exp_data();
    if (pos < 3) return 8'h7F;
    if (pos < 8) return ctrl_q[8*(7-pos) +: 8];
    if (pos < GEND) return q[0];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s NRX=%0d pos=%0d actual=%0h expected=%0h", tag, NRX, pos, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      was_rst = 1;
    end else begin
      chk(dut_valid == exp_valid(), (pos >= 8 && pos < GEND) ? "R6 valid" : "R2/R8 valid",
          dut_valid, exp_valid());
      if (exp_valid()) begin
        if (pos == 0)       chk(dut_data == exp_data(), "R1 R2 frame start", dut_data, exp_data());
        else if (pos < 3)   chk(dut_data == exp_data(), "R2 sync", dut_data, exp_data());
        else if (pos < 8)   chk(dut_data == exp_data(), "R3 R4 ctrl", dut_data, exp_data());
        else if (pos < GEND) chk(dut_data == exp_data(), "R5 group byte", dut_data, exp_data());
        else                chk(dut_data == exp_data(), "R8 pad", dut_data, exp_data());
      end
      chk(dut_ovf == ov_exp, "R9 overflow", dut_ovf, ov_exp);
      if (!was_rst && pv && !pr)
        chk(dut_valid && dut_data == pd, "R7 stall hold", {dut_valid, dut_data}, {1'b1, pd});
      pv = dut_valid; pr = ready; pd = dut_data;
      was_rst = 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = 0; gidx = 0; q.delete(); full = 0; ov_exp = 0; ctrl_q = '0;
    end else begin
      bit fire, in_grp, done, allv;
      fire   = exp_valid() && ready;
      in_grp = pos >= 8 && pos < GEND;
      done   = fire && in_grp && gidx == G - 1;
      allv   = (&rx_valid) && aud_valid;
      ov_exp = allv && full && !done;
      if (fire) begin
        if (pos == 0) ctrl_q = ctrl;
        if (in_grp) begin
          void'(q.pop_front());
          gidx = done ? 0 : gidx + 1;
        end
        if (pos == FRAME - 1) begin
          pos = 0;
          frames++;
        end else pos++;
      end
      if (allv && (!full || done)) begin
        q.delete();
        for (int r = 0; r < NRX; r++) begin
          for (int b = 2; b >= 0; b--) q.push_back(rx_i[24*r + 8*b +: 8]);
          for (int b = 2; b >= 0; b--) q.push_back(rx_q[24*r + 8*b +: 8]);
        end
        q.push_back(aud[15:8]);
        q.push_back(aud[7:0]);
        full = 1;
      end else if (done) full = 0;
    end
  end
endmodule

module test_iq_frame_packer;
  logic clk = 0;
  always #10 clk = ~clk;

  logic        rst_n = 0;
  logic [71:0] rx_i = '0, rx_q = '0;
  logic [2:0]  rx_valid = '0;
  logic [15:0] aud = '0;
  logic        aud_valid = 0;
  logic [39:0] ctrl = 40'h11_22_33_44_55;
  logic        ready = 1;
  logic [7:0]  d2, d3;
  logic        v2, v3, o2, o3;
  int          mode = 0;
  int          n_chk = 0, n_fail = 0;

  iq_frame_packer #(.NUM_RX(2), .FRAME_BYTES(512)) i_iq_frame_packer (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i[47:0]), .rx_q(rx_q[47:0]),
    .rx_valid(rx_valid[1:0]), .aud_sample(aud), .aud_valid(aud_valid),
    .ctrl_bytes(ctrl), .out_data(d2), .out_valid(v2), .out_ready(ready),
    .overflow(o2));

  iq_frame_packer #(.NUM_RX(3), .FRAME_BYTES(512)) i_iq_frame_packer_w3 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .rx_q(rx_q),
    .rx_valid(rx_valid), .aud_sample(aud), .aud_valid(aud_valid),
    .ctrl_bytes(ctrl), .out_data(d3), .out_valid(v3), .out_ready(ready),
    .overflow(o3));

  packer_ref_model #(.NRX(2), .FRAME(512)) m2 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i[47:0]), .rx_q(rx_q[47:0]),
    .rx_valid(rx_valid[1:0]), .aud(aud), .aud_valid(aud_valid), .ctrl(ctrl),
    .ready(ready), .dut_data(d2), .dut_valid(v2), .dut_ovf(o2));

  packer_ref_model #(.NRX(3), .FRAME(512)) m3 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .rx_q(rx_q),
    .rx_valid(rx_valid), .aud(aud), .aud_valid(aud_valid), .ctrl(ctrl),
    .ready(ready), .dut_data(d3), .dut_valid(v3), .dut_ovf(o3));

  task automatic tb_chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + m2.n_chk + m3.n_chk, n_fail + m2.n_fail + m3.n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      rx_i <= {$urandom, $urandom, $urandom};
      rx_q <= {$urandom, $urandom, $urandom};
      aud  <= 16'($urandom);
      case (mode)
        0: begin rx_valid <= 3'b111; aud_valid <= 1; ready <= 1; end
        1: begin rx_valid <= 3'($urandom); aud_valid <= ($urandom % 4) != 0; ready <= 1; end
        2: begin rx_valid <= 3'b111; aud_valid <= 1; ready <= ($urandom % 3) != 0; end
        default: begin
          rx_valid <= ($urandom % 3) == 0 ? 3'($urandom) : 3'b111;
          aud_valid <= ($urandom % 5) != 0;
          ready <= ($urandom % 4) != 0;
          ctrl <= {$urandom, 8'($urandom)};
        end
      endcase
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state on both instances
    tb_chk(v2 == 1 && d2 == 8'h7F && o2 == 0, "R10 reset state NRX=2", {v2, d2, o2}, {1'b1, 8'h7F, 1'b0});
    tb_chk(v3 == 1 && d3 == 8'h7F && o3 == 0, "R10 reset state NRX=3", {v3, d3, o3}, {1'b1, 8'h7F, 1'b0});
    rst_n = 1;
    mode = 0; repeat (1200) @(posedge clk);
    mode = 1; repeat (2500) @(posedge clk);
    mode = 2; repeat (1500) @(posedge clk);
    mode = 3; repeat (3000) @(posedge clk);
    @(negedge clk);
    // R1: frames completed on each instance
    tb_chk(m2.frames >= 4, "R1 frames done NRX=2", m2.frames, 4);
    tb_chk(m3.frames >= 4, "R1 frames done NRX=3", m3.frames, 4);
    finish_run();
  end
endmodule